// File: doc/BRIEF.md
# IPv4 Address and Port Translation Header Rewriter

This unit sits after the connection-table search in a packet forwarding path. For every parsed packet it receives the extracted header fields (Ethernet addresses, TTL, protocol number, IPv4 addresses, transport ports and both checksums), the table hit flag and the parameters of the table entry that matched. From these it produces the rewritten header fields and a verdict: the packet is either handed to the hardware forwarding path with its new header, or sent to the host processor unchanged.

A packet is translated in hardware only when all of the following hold: it is IPv4, it carries TCP or UDP, its four-part address and port key matched one entry, and its TTL is above 1. IPsec packets (AH or ESP) are always sent to the host. On a hit, the unit does four things. It substitutes both Ethernet addresses from the entry. It lowers the TTL by one. It overwrites either the source or the destination address-and-port pair, as the entry selects. It then repairs the IPv4 header checksum and the TCP/UDP checksum incrementally, without touching the payload. The entry also supplies the egress interface, which goes out alongside the result.

The unit is a two-stage pipeline with a valid/ready handshake on both sides. It accepts one packet per cycle and presents the result exactly two cycles after acceptance when the consumer is ready.

Top module: `nat_rewrite`

## Requirements
- R1: `outReason` reports the verdict with this priority: 1 when the packet is not IPv4, 2 when it is IPv4 AH or ESP (protocol 51 or 50), 3 when it is IPv4 and neither TCP (6) nor UDP (17), 4 when the table did not hit, 5 when TTL is 0 or 1, and otherwise 0. `outForward` is 1 exactly when the code is 0.
- R2: An IPv4 packet with protocol 50 or 51 is never forwarded, even when the table hit and the TTL is valid.
- R3: A packet that is not forwarded leaves with every MAC, TTL, address, port and checksum output equal to its input value.
- R4: A forwarded packet carries the entry's destination and source MAC addresses and a TTL one lower than received. It also carries the entry's egress interface and its table index.
- R5: On a forwarded packet, when `entRewriteDst` is 1 the destination address and port are replaced by `entIp`/`entPort` and the source pair is kept. When it is 0, the source pair is replaced and the destination pair is kept.
- R6: The IPv4 header checksum of a forwarded packet equals a full recomputation over the rewritten header.
- R7: The TCP/UDP checksum of a forwarded packet equals a full recomputation over the pseudo-header and segment with the rewritten addresses and ports. A UDP result of 0x0000 is sent as 0xFFFF.
- R8: A forwarded UDP packet that arrives with checksum 0x0000 (checksum disabled) leaves with 0x0000.
- R9: With `outReady` high, a packet accepted at one clock edge is presented on the outputs after the second following edge, and back-to-back packets flow one per cycle.
- R10: While `outValid` is high and `outReady` is low, all outputs hold their values and `inReady` is low.
- R11: During and after reset, `outValid` is 0 and `inReady` is 1 until a packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input packet header valid |
| inReady | output | 1 | Unit can accept a header |
| inIsIpv4 | input | 1 | Packet is IPv4 |
| inMatch | input | 1 | Table search hit |
| inEntryIdx | input | IDX_W (7) | Index of the matching entry |
| inProto | input | 8 | IP protocol number |
| inTtl | input | 8 | Received TTL |
| inMacDa | input | 48 | Received Ethernet destination |
| inMacSa | input | 48 | Received Ethernet source |
| inSrcIp | input | 32 | Received source address |
| inDstIp | input | 32 | Received destination address |
| inSrcPort | input | 16 | Received source port |
| inDstPort | input | 16 | Received destination port |
| inIpCsum | input | 16 | Received IPv4 header checksum |
| inL4Csum | input | 16 | Received TCP/UDP checksum |
| entMacDa | input | 48 | Entry: new Ethernet destination |
| entMacSa | input | 48 | Entry: new Ethernet source |
| entIp | input | 32 | Entry: replacement address |
| entPort | input | 16 | Entry: replacement port |
| entRewriteDst | input | 1 | Entry: 1 rewrites destination pair, 0 rewrites source pair |
| entEgress | input | EGR_W (2) | Entry: egress interface |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer accepts result |
| outForward | output | 1 | 1 forward in hardware, 0 send to host |
| outReason | output | 3 | Verdict code (R1) |
| outEntryIdx | output | IDX_W (7) | Entry index |
| outEgress | output | EGR_W (2) | Egress interface |
| outMacDa | output | 48 | Ethernet destination out |
| outMacSa | output | 48 | Ethernet source out |
| outTtl | output | 8 | TTL out |
| outSrcIp | output | 32 | Source address out |
| outDstIp | output | 32 | Destination address out |
| outSrcPort | output | 16 | Source port out |
| outDstPort | output | 16 | Destination port out |
| outIpCsum | output | 16 | IPv4 header checksum out |
| outL4Csum | output | 16 | TCP/UDP checksum out |

## Verification
The assertions check four properties on every cycle. A stalled result stays valid with all its data frozen. An IPsec packet is never forwarded. A forwarded TTL is never zero. A disabled UDP checksum survives translation as zero. Only the bench's scenarios can show that the incremental checksums agree with a full recomputation, and that the verdict priority is right across the sweep of protocol, TTL, hit flag and IP version. The same holds for the choice of rewritten pair, the 0xFFFF substitution for a zero UDP result, and the exact two-cycle latency with back-to-back and stalled traffic.

// File: rtl/nat_rw_pkg.sv
package nat_rw_pkg;

  localparam int MAC_W  = 48;
  localparam int IP_W   = 32;
  localparam int PORT_W = 16;
  localparam int CSUM_W = 16;

  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;
  localparam logic [7:0] PROTO_ESP = 8'd50;
  localparam logic [7:0] PROTO_AH  = 8'd51;

  typedef enum logic [2:0] {
    RSN_NONE   = 3'd0,
    RSN_NOT_V4 = 3'd1,
    RSN_IPSEC  = 3'd2,
    RSN_NOT_L4 = 3'd3,
    RSN_MISS   = 3'd4,
    RSN_TTL    = 3'd5
  } punt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // pipeline moves this cycle
    logic fwdS1;    // packet in stage 1 is to be rewritten
  } rw_strobe_t;

  // one's-complement 16-bit add with end-around carry
  function automatic logic [CSUM_W-1:0] onesAdd(input logic [CSUM_W-1:0] a,
                                               input logic [CSUM_W-1:0] b);
    logic [CSUM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, s[CSUM_W]};
  endfunction

endpackage

// File: rtl/nat_rw_ctrl.sv
module nat_rw_ctrl
  import nat_rw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       inIsIpv4,
  input  logic       inMatch,
  input  logic [7:0] inProto,
  input  logic [7:0] inTtl,
  output logic       inReady,
  output logic       outValid,
  output logic       outForward,
  output logic [2:0] outReason,
  output rw_strobe_t strobe
);

  punt_e decide;
  logic  isIpsec;
  logic  isL4;

  assign isIpsec = (inProto == PROTO_ESP) || (inProto == PROTO_AH);
  assign isL4    = (inProto == PROTO_TCP) || (inProto == PROTO_UDP);

  always_comb begin
    if (!inIsIpv4)          decide = RSN_NOT_V4;
    else if (isIpsec)       decide = RSN_IPSEC;
    else if (!isL4)         decide = RSN_NOT_L4;
    else if (!inMatch)      decide = RSN_MISS;
    else if (inTtl <= 8'd1) decide = RSN_TTL;
    else                    decide = RSN_NONE;
  end

  logic  s1Valid, s2Valid;
  punt_e s1Reason, s2Reason;
  logic  s1Ipsec, s2Ipsec;
  logic  advance;

  assign advance = !s2Valid || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      s1Reason <= RSN_NONE;
      s2Reason <= RSN_NONE;
      s1Ipsec  <= 1'b0;
      s2Ipsec  <= 1'b0;
    end else if (advance) begin
      s1Valid  <= inValid;
      s1Reason <= decide;
      s1Ipsec  <= inIsIpv4 && isIpsec;
      s2Valid  <= s1Valid;
      s2Reason <= s1Reason;
      s2Ipsec  <= s1Ipsec;
    end
  end

  assign inReady        = advance;
  assign outValid       = s2Valid;
  assign outForward     = s2Valid && (s2Reason == RSN_NONE);
  assign outReason      = s2Reason;
  assign strobe.advance = advance;
  assign strobe.fwdS1   = (s1Reason == RSN_NONE);

  // R10: a stalled result stays presented
  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R2: IPsec traffic always reaches the host
  a_r2_ipsec_punt: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && s2Ipsec) |-> (!outForward && outReason == RSN_IPSEC));

endmodule

// File: rtl/nat_rw_datapath.sv
module nat_rw_datapath
  import nat_rw_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int EGR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rw_strobe_t        strobe,
  input  logic [IDX_W-1:0]  inEntryIdx,
  input  logic [7:0]        inProto,
  input  logic [7:0]        inTtl,
  input  logic [MAC_W-1:0]  inMacDa,
  input  logic [MAC_W-1:0]  inMacSa,
  input  logic [IP_W-1:0]   inSrcIp,
  input  logic [IP_W-1:0]   inDstIp,
  input  logic [PORT_W-1:0] inSrcPort,
  input  logic [PORT_W-1:0] inDstPort,
  input  logic [CSUM_W-1:0] inIpCsum,
  input  logic [CSUM_W-1:0] inL4Csum,
  input  logic [MAC_W-1:0]  entMacDa,
  input  logic [MAC_W-1:0]  entMacSa,
  input  logic [IP_W-1:0]   entIp,
  input  logic [PORT_W-1:0] entPort,
  input  logic              entRewriteDst,
  input  logic [EGR_W-1:0]  entEgress,
  output logic [IDX_W-1:0]  outEntryIdx,
  output logic [EGR_W-1:0]  outEgress,
  output logic [MAC_W-1:0]  outMacDa,
  output logic [MAC_W-1:0]  outMacSa,
  output logic [7:0]        outTtl,
  output logic [IP_W-1:0]   outSrcIp,
  output logic [IP_W-1:0]   outDstIp,
  output logic [PORT_W-1:0] outSrcPort,
  output logic [PORT_W-1:0] outDstPort,
  output logic [CSUM_W-1:0] outIpCsum,
  output logic [CSUM_W-1:0] outL4Csum
);

  localparam int HALF = IP_W / 2;

  // ---------------- stage 1: capture and per-word deltas ----------------
  logic [IP_W-1:0]   oldIp;
  logic [PORT_W-1:0] oldPort;
  logic [7:0]        ttlDec;
  logic [CSUM_W-1:0] dIpNext, dPortNext, dTtlNext;

  assign oldIp   = entRewriteDst ? inDstIp : inSrcIp;
  assign oldPort = entRewriteDst ? inDstPort : inSrcPort;
  assign ttlDec  = inTtl - 8'd1;

  assign dIpNext   = onesAdd(onesAdd(~oldIp[IP_W-1:HALF], ~oldIp[HALF-1:0]),
                             onesAdd(entIp[IP_W-1:HALF], entIp[HALF-1:0]));
  assign dPortNext = onesAdd(~oldPort, entPort);
  assign dTtlNext  = onesAdd(~{inTtl, inProto}, {ttlDec, inProto});

  logic [IDX_W-1:0]  s1Idx;
  logic [EGR_W-1:0]  s1Egress;
  logic [7:0]        s1Proto, s1Ttl;
  logic [MAC_W-1:0]  s1MacDa, s1MacSa, s1EntMacDa, s1EntMacSa;
  logic [IP_W-1:0]   s1SrcIp, s1DstIp, s1EntIp;
  logic [PORT_W-1:0] s1SrcPort, s1DstPort, s1EntPort;
  logic [CSUM_W-1:0] s1IpCsum, s1L4Csum, s1DIp, s1DPort, s1DTtl;
  logic              s1RwDst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Idx <= '0;       s1Egress <= '0;    s1Proto <= '0;    s1Ttl <= '0;
      s1MacDa <= '0;     s1MacSa <= '0;     s1EntMacDa <= '0; s1EntMacSa <= '0;
      s1SrcIp <= '0;     s1DstIp <= '0;     s1EntIp <= '0;
      s1SrcPort <= '0;   s1DstPort <= '0;   s1EntPort <= '0;
      s1IpCsum <= '0;    s1L4Csum <= '0;
      s1DIp <= '0;       s1DPort <= '0;     s1DTtl <= '0;     s1RwDst <= 1'b0;
    end else if (strobe.advance) begin
      s1Idx      <= inEntryIdx;
      s1Egress   <= entEgress;
      s1Proto    <= inProto;
      s1Ttl      <= inTtl;
      s1MacDa    <= inMacDa;
      s1MacSa    <= inMacSa;
      s1EntMacDa <= entMacDa;
      s1EntMacSa <= entMacSa;
      s1SrcIp    <= inSrcIp;
      s1DstIp    <= inDstIp;
      s1EntIp    <= entIp;
      s1SrcPort  <= inSrcPort;
      s1DstPort  <= inDstPort;
      s1EntPort  <= entPort;
      s1IpCsum   <= inIpCsum;
      s1L4Csum   <= inL4Csum;
      s1DIp      <= dIpNext;
      s1DPort    <= dPortNext;
      s1DTtl     <= dTtlNext;
      s1RwDst    <= entRewriteDst;
    end
  end

  // ---------------- stage 2: fold deltas into checksums ----------------
  logic [CSUM_W-1:0] ipNew, l4Raw, l4New;
  logic              s1IsUdp, s1UdpOff;

  assign ipNew    = ~onesAdd(onesAdd(~s1IpCsum, s1DIp), s1DTtl);
  assign l4Raw    = ~onesAdd(onesAdd(~s1L4Csum, s1DIp), s1DPort);
  assign s1IsUdp  = (s1Proto == PROTO_UDP);
  assign s1UdpOff = s1IsUdp && (s1L4Csum == '0);

  always_comb begin
    if (s1UdpOff)                   l4New = '0;
    else if (s1IsUdp && l4Raw == '0) l4New = '1;
    else                            l4New = l4Raw;
  end

  logic s2Rewritten, s2UdpOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outEntryIdx <= '0; outEgress <= '0; outMacDa <= '0; outMacSa <= '0;
      outTtl <= '0;      outSrcIp <= '0;  outDstIp <= '0;
      outSrcPort <= '0;  outDstPort <= '0;
      outIpCsum <= '0;   outL4Csum <= '0;
      s2Rewritten <= 1'b0; s2UdpOff <= 1'b0;
    end else if (strobe.advance) begin
      outEntryIdx <= s1Idx;
      outEgress   <= s1Egress;
      s2Rewritten <= strobe.fwdS1;
      s2UdpOff    <= s1UdpOff;
      if (strobe.fwdS1) begin
        outMacDa  <= s1EntMacDa;
        outMacSa  <= s1EntMacSa;
        outTtl    <= s1Ttl - 8'd1;
        outIpCsum <= ipNew;
        outL4Csum <= l4New;
        if (s1RwDst) begin
          outSrcIp   <= s1SrcIp;
          outSrcPort <= s1SrcPort;
          outDstIp   <= s1EntIp;
          outDstPort <= s1EntPort;
        end else begin
          outSrcIp   <= s1EntIp;
          outSrcPort <= s1EntPort;
          outDstIp   <= s1DstIp;
          outDstPort <= s1DstPort;
        end
      end else begin
        outMacDa   <= s1MacDa;
        outMacSa   <= s1MacSa;
        outTtl     <= s1Ttl;
        outIpCsum  <= s1IpCsum;
        outL4Csum  <= s1L4Csum;
        outSrcIp   <= s1SrcIp;
        outSrcPort <= s1SrcPort;
        outDstIp   <= s1DstIp;
        outDstPort <= s1DstPort;
      end
    end
  end

  // R10: frozen result while the pipeline is stalled
  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> ($stable(outTtl) && $stable(outSrcIp) && $stable(outDstIp) &&
                         $stable(outSrcPort) && $stable(outDstPort) && $stable(outMacDa) &&
                         $stable(outMacSa) && $stable(outIpCsum) && $stable(outL4Csum)));

  // R4: a rewritten packet never leaves with TTL zero
  a_r4_ttl_floor: assert property (@(posedge clk) disable iff (!rstN)
    s2Rewritten |-> (outTtl != 8'd0));

  // R8: disabled UDP checksum stays disabled
  a_r8_udp_off: assert property (@(posedge clk) disable iff (!rstN)
    (s2Rewritten && s2UdpOff) |-> (outL4Csum == '0));

endmodule

// File: rtl/nat_rewrite.sv
module nat_rewrite
  import nat_rw_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int EGR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inIsIpv4,
  input  logic              inMatch,
  input  logic [IDX_W-1:0]  inEntryIdx,
  input  logic [7:0]        inProto,
  input  logic [7:0]        inTtl,
  input  logic [47:0]       inMacDa,
  input  logic [47:0]       inMacSa,
  input  logic [31:0]       inSrcIp,
  input  logic [31:0]       inDstIp,
  input  logic [15:0]       inSrcPort,
  input  logic [15:0]       inDstPort,
  input  logic [15:0]       inIpCsum,
  input  logic [15:0]       inL4Csum,
  input  logic [47:0]       entMacDa,
  input  logic [47:0]       entMacSa,
  input  logic [31:0]       entIp,
  input  logic [15:0]       entPort,
  input  logic              entRewriteDst,
  input  logic [EGR_W-1:0]  entEgress,
  output logic              outValid,
  input  logic              outReady,
  output logic              outForward,
  output logic [2:0]        outReason,
  output logic [IDX_W-1:0]  outEntryIdx,
  output logic [EGR_W-1:0]  outEgress,
  output logic [47:0]       outMacDa,
  output logic [47:0]       outMacSa,
  output logic [7:0]        outTtl,
  output logic [31:0]       outSrcIp,
  output logic [31:0]       outDstIp,
  output logic [15:0]       outSrcPort,
  output logic [15:0]       outDstPort,
  output logic [15:0]       outIpCsum,
  output logic [15:0]       outL4Csum
);

  rw_strobe_t strobe;

  nat_rw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .outReady   (outReady),
    .inIsIpv4   (inIsIpv4),
    .inMatch    (inMatch),
    .inProto    (inProto),
    .inTtl      (inTtl),
    .inReady    (inReady),
    .outValid   (outValid),
    .outForward (outForward),
    .outReason  (outReason),
    .strobe     (strobe)
  );

  nat_rw_datapath #(.IDX_W(IDX_W), .EGR_W(EGR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .inEntryIdx    (inEntryIdx),
    .inProto       (inProto),
    .inTtl         (inTtl),
    .inMacDa       (inMacDa),
    .inMacSa       (inMacSa),
    .inSrcIp       (inSrcIp),
    .inDstIp       (inDstIp),
    .inSrcPort     (inSrcPort),
    .inDstPort     (inDstPort),
    .inIpCsum      (inIpCsum),
    .inL4Csum      (inL4Csum),
    .entMacDa      (entMacDa),
    .entMacSa      (entMacSa),
    .entIp         (entIp),
    .entPort       (entPort),
    .entRewriteDst (entRewriteDst),
    .entEgress     (entEgress),
    .outEntryIdx   (outEntryIdx),
    .outEgress     (outEgress),
    .outMacDa      (outMacDa),
    .outMacSa      (outMacSa),
    .outTtl        (outTtl),
    .outSrcIp      (outSrcIp),
    .outDstIp      (outDstIp),
    .outSrcPort    (outSrcPort),
    .outDstPort    (outDstPort),
    .outIpCsum     (outIpCsum),
    .outL4Csum     (outL4Csum)
  );

endmodule

// File: tb/tb_nat_rewrite.sv
module tb_nat_rewrite;

  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic inValid = 0, inReady, inIsIpv4 = 0, inMatch = 0;
  logic [6:0] inEntryIdx = '0;
  logic [7:0] inProto = '0, inTtl = '0;
  logic [47:0] inMacDa = '0, inMacSa = '0, entMacDa = '0, entMacSa = '0;
  logic [31:0] inSrcIp = '0, inDstIp = '0, entIp = '0;
  logic [15:0] inSrcPort = '0, inDstPort = '0, inIpCsum = '0, inL4Csum = '0, entPort = '0;
  logic entRewriteDst = 0;
  logic [1:0] entEgress = '0;
  logic outValid, outReady = 1, outForward;
  logic [2:0] outReason;
  logic [6:0] outEntryIdx;
  logic [1:0] outEgress;
  logic [47:0] outMacDa, outMacSa;
  logic [7:0] outTtl;
  logic [31:0] outSrcIp, outDstIp;
  logic [15:0] outSrcPort, outDstPort, outIpCsum, outL4Csum;

  nat_rewrite dut (.*);

  typedef struct packed {
    logic ipv4; logic match; logic [7:0] proto; logic [7:0] ttl; logic [6:0] idx;
    logic [47:0] macDa; logic [47:0] macSa; logic [31:0] src; logic [31:0] dst;
    logic [15:0] sp; logic [15:0] dp; logic [15:0] len; logic [15:0] id; logic [15:0] pay;
    logic udpOff; logic [47:0] eMacDa; logic [47:0] eMacSa; logic [31:0] eIp;
    logic [15:0] ePort; logic rwDst; logic [1:0] egress;
  } pkt_t;

  typedef struct packed {
    logic fwd; logic [2:0] reason; logic [6:0] idx; logic [1:0] egress;
    logic [47:0] macDa; logic [47:0] macSa; logic [7:0] ttl; logic [31:0] src; logic [31:0] dst;
    logic [15:0] sp; logic [15:0] dp; logic [15:0] ipC; logic [15:0] l4C;
  } exp_t;

  int checks = 0;
  int errors = 0;
  logic [31:0] rnd = 32'h1234_5678;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] fold(input logic [31:0] s);
    logic [31:0] t = s;
    for (int i = 0; i < 4; i++) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
    return t[15:0];
  endfunction

  // full IPv4 header checksum over a fixed header layout
  function automatic logic [15:0] ipFull(input pkt_t p, input logic [7:0] ttl,
                                         input logic [31:0] s, input logic [31:0] d);
    logic [31:0] sum;
    sum = 32'h4500 + p.len + p.id + 32'h4000 + {16'd0, ttl, p.proto}
        + s[31:16] + s[15:0] + d[31:16] + d[15:0];
    return ~fold(sum);
  endfunction

  // full transport checksum before any zero substitution
  function automatic logic [15:0] l4Raw(input pkt_t p, input logic [31:0] s, input logic [31:0] d,
                                        input logic [15:0] sp, input logic [15:0] dp);
    logic [31:0] sum;
    sum = s[31:16] + s[15:0] + d[31:16] + d[15:0] + p.proto + p.len + sp + dp + p.pay;
    return ~fold(sum);
  endfunction

  function automatic logic [15:0] l4Full(input pkt_t p, input logic [31:0] s, input logic [31:0] d,
                                         input logic [15:0] sp, input logic [15:0] dp);
    logic [15:0] c = l4Raw(p, s, d, sp, dp);
    if (p.proto == 8'd17 && c == 16'h0) c = 16'hFFFF;
    return c;
  endfunction

  function automatic logic [15:0] inL4Of(input pkt_t p);
    if (p.udpOff && p.proto == 8'd17) return 16'h0;
    return l4Full(p, p.src, p.dst, p.sp, p.dp);
  endfunction

  function automatic exp_t expectOf(input pkt_t p);
    exp_t e;
    logic [2:0] r;
    if (!p.ipv4) r = 3'd1;
    else if (p.proto == 8'd50 || p.proto == 8'd51) r = 3'd2;
    else if (p.proto != 8'd6 && p.proto != 8'd17) r = 3'd3;
    else if (!p.match) r = 3'd4;
    else if (p.ttl <= 8'd1) r = 3'd5;
    else r = 3'd0;
    e.reason = r; e.fwd = (r == 3'd0); e.idx = p.idx; e.egress = p.egress;
    if (e.fwd) begin
      e.macDa = p.eMacDa; e.macSa = p.eMacSa; e.ttl = p.ttl - 8'd1;
      e.src = p.rwDst ? p.src : p.eIp;   e.sp = p.rwDst ? p.sp : p.ePort;
      e.dst = p.rwDst ? p.eIp : p.dst;   e.dp = p.rwDst ? p.ePort : p.dp;
      e.ipC = ipFull(p, e.ttl, e.src, e.dst);
      if (p.udpOff && p.proto == 8'd17) e.l4C = 16'h0;
      else e.l4C = l4Full(p, e.src, e.dst, e.sp, e.dp);
    end else begin
      e.macDa = p.macDa; e.macSa = p.macSa; e.ttl = p.ttl;
      e.src = p.src; e.dst = p.dst; e.sp = p.sp; e.dp = p.dp;
      e.ipC = ipFull(p, p.ttl, p.src, p.dst);
      e.l4C = inL4Of(p);
    end
    return e;
  endfunction

  task automatic nextRand();
    rnd = rnd * 32'd1103515245 + 32'd12345;
  endtask

  task automatic makePkt(output pkt_t p);
    nextRand(); p.src = rnd;    nextRand(); p.dst = rnd;
    nextRand(); p.sp = rnd[31:16]; p.dp = rnd[15:0];
    nextRand(); p.eIp = rnd;    nextRand(); p.ePort = rnd[31:16]; p.pay = rnd[15:0];
    nextRand(); p.macDa = {rnd[15:0], rnd}; nextRand(); p.macSa = {rnd, rnd[31:16]};
    nextRand(); p.eMacDa = {rnd[31:16], rnd}; nextRand(); p.eMacSa = {rnd[15:0], ~rnd};
    nextRand(); p.len = {4'd0, rnd[27:16]}; p.id = rnd[15:0];
    p.idx = rnd[6:0]; p.egress = rnd[9:8];
    p.ipv4 = 1; p.match = 1; p.proto = 8'd6; p.ttl = 8'd64; p.udpOff = 0; p.rwDst = 0;
  endtask

  task automatic drive(input pkt_t p);
    inValid = 1; inIsIpv4 = p.ipv4; inMatch = p.match; inEntryIdx = p.idx;
    inProto = p.proto; inTtl = p.ttl; inMacDa = p.macDa; inMacSa = p.macSa;
    inSrcIp = p.src; inDstIp = p.dst; inSrcPort = p.sp; inDstPort = p.dp;
    inIpCsum = ipFull(p, p.ttl, p.src, p.dst); inL4Csum = inL4Of(p);
    entMacDa = p.eMacDa; entMacSa = p.eMacSa; entIp = p.eIp; entPort = p.ePort;
    entRewriteDst = p.rwDst; entEgress = p.egress;
  endtask

  task automatic checkOut(input exp_t e);
    chk("R9 outValid", 64'(outValid), 64'd1);
    chk("R1 reason", 64'(outReason), 64'(e.reason));
    chk("R1 forward", 64'(outForward), 64'(e.fwd));
    if (e.reason == 3'd2) chk("R2 ipsec not forwarded", 64'(outForward), 64'd0);
    if (e.fwd) begin
      chk("R4 macDa", 64'(outMacDa), 64'(e.macDa));
      chk("R4 macSa", 64'(outMacSa), 64'(e.macSa));
      chk("R4 ttl", 64'(outTtl), 64'(e.ttl));
      chk("R4 egress", 64'(outEgress), 64'(e.egress));
      chk("R4 index", 64'(outEntryIdx), 64'(e.idx));
      chk("R5 addresses", {outSrcIp, outDstIp}, {e.src, e.dst});
      chk("R5 ports", {32'd0, outSrcPort, outDstPort}, {32'd0, e.sp, e.dp});
      chk("R6 ip checksum", 64'(outIpCsum), 64'(e.ipC));
      chk("R7 l4 checksum", 64'(outL4Csum), 64'(e.l4C));
    end else begin
      chk("R3 macs", {16'd0, outMacDa}, {16'd0, e.macDa});
      chk("R3 macSa ttl", {8'd0, outMacSa, outTtl}, {8'd0, e.macSa, e.ttl});
      chk("R3 addresses", {outSrcIp, outDstIp}, {e.src, e.dst});
      chk("R3 ports csums", {outSrcPort, outDstPort, outIpCsum, outL4Csum},
                            {e.sp, e.dp, e.ipC, e.l4C});
    end
  endtask

  // one packet, checking the two-cycle latency
  task automatic runOne(input pkt_t p);
    exp_t e = expectOf(p);
    @(negedge clk); drive(p);
    @(posedge clk);
    @(negedge clk); inValid = 0;
    chk("R9 not yet valid", 64'(outValid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    checkOut(e);
  endtask

  logic [7:0] protoList [5] = '{8'd6, 8'd17, 8'd50, 8'd51, 8'd1};
  logic [7:0] ttlList   [5] = '{8'd0, 8'd1, 8'd2, 8'd64, 8'd255};

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pkt_t p, q[3];
    exp_t e, eq[3];
    logic [15:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 outValid in reset", 64'(outValid), 64'd0);
    rstN = 1;
    @(negedge clk);
    chk("R11 outValid after reset", 64'(outValid), 64'd0);
    chk("R11 inReady after reset", 64'(inReady), 64'd1);

    // sweep: protocol x TTL x version x hit x direction (R1 R2 R3 R4 R5 R6 R7 R8)
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 2; d++)
            for (int f = 0; f < 2; f++) begin
              makePkt(p);
              p.proto = protoList[a]; p.ttl = ttlList[b];
              p.ipv4 = c[0]; p.match = d[0]; p.rwDst = f[0];
              p.udpOff = (p.proto == 8'd17) && (b == 3) && (f == 1);
              runOne(p);
            end

    // R8: disabled UDP checksum on a forwarded packet
    makePkt(p); p.proto = 8'd17; p.udpOff = 1; p.rwDst = 1;
    runOne(p);
    chk("R8 udp zero kept", 64'(outL4Csum), 64'd0);

    // R7: forwarded UDP whose recomputed checksum is zero is sent as all ones
    makePkt(p); p.proto = 8'd17; p.rwDst = 0; p.pay = 16'd0;
    r = l4Raw(p, p.eIp, p.dst, p.ePort, p.dp);
    p.pay = r;
    runOne(p);
    chk("R7 udp zero result as FFFF", 64'(outL4Csum), 64'hFFFF);

    // R9: back-to-back packets, one per cycle
    for (int i = 0; i < 3; i++) begin
      makePkt(q[i]); q[i].rwDst = i[0]; q[i].proto = (i == 1) ? 8'd17 : 8'd6;
      eq[i] = expectOf(q[i]);
    end
    @(negedge clk); drive(q[0]);
    @(negedge clk); drive(q[1]);
    @(negedge clk); drive(q[2]); checkOut(eq[0]);
    @(negedge clk); inValid = 0;  checkOut(eq[1]);
    @(negedge clk); checkOut(eq[2]);
    @(negedge clk); chk("R9 drained", 64'(outValid), 64'd0);

    // R10: stall holds the result and blocks input
    makePkt(q[0]); q[0].rwDst = 1; eq[0] = expectOf(q[0]);
    makePkt(q[1]); q[1].proto = 8'd17; eq[1] = expectOf(q[1]);
    outReady = 0;
    @(negedge clk); drive(q[0]);
    @(posedge clk);
    @(negedge clk); inValid = 0;
    @(posedge clk);
    @(negedge clk); drive(q[1]);
    for (int k = 0; k < 3; k++) begin
      checkOut(eq[0]);
      chk("R10 inReady low while stalled", 64'(inReady), 64'd0);
      @(negedge clk);
    end
    outReady = 1;
    @(posedge clk);
    @(negedge clk); inValid = 0;
    chk("R10 bubble after release", 64'(outValid), 64'd0);
    @(posedge clk);
    @(negedge clk);
    checkOut(eq[1]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule